// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a two-wire (I2C-compatible) slave that gives a bus master access to eight 8-bit registers. It oversamples SCL and SDA with the system clock, finds start and stop conditions, and answers one of two 7-bit device addresses. The second byte of a write names a starting register. The bytes after it are written to that register and to the ones that follow it. A read uses a write that carries only the register number, then a repeated start with the read bit set. Read data then begins at the stored register and steps forward after each byte.

Registers 0 to 5 are control registers. They reset to 0x00 and appear as parallel outputs. Registers 6 and 7 return two status bytes taken from input pins. The slave pulls SDA low through a single open-drain enable and never drives the line high.

The bus carries no flow control, so no valid/ready handshake is used: the master paces every bit through SCL and there is no back-pressure at any port. Every pin is a plain level.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, every control register reads 0x00 on `ctrl_o` and `sda_pull_o` is 0.
- R2: The device address is 0x40 when `addr_strap_i` is 0 and 0x60 when it is 1. On a match, the slave holds SDA low during the ninth SCL pulse.
- R3: A first byte with any other address gets no acknowledge. The slave then ignores every following byte until the next start: no acknowledge is given and no register changes.
- R4: In a write, the second byte is the subaddress. Each data byte goes to the current register and is acknowledged. The new value appears on `ctrl_o` (register k at bits 8k+7:8k) before the acknowledge pulse.
- R5: After each data byte, written or read, the register pointer advances by one. It stops at register 7.
- R6: A subaddress of 8 or more is not acknowledged. The slave returns to idle, and the data bytes that follow are neither acknowledged nor written.
- R7: A subaddress-only write followed by a repeated start and the read address (R/W = 1) returns the registers MSB first, starting at that subaddress. Registers 6 and 7 return `stat_i[7:0]` and `stat_i[15:8]`.
- R8: A read that passes register 7 keeps returning register 7. A master no-acknowledge ends the read, and the slave does not pull SDA low again until the next start.
- R9: A stop in the middle of a byte aborts the transfer with no write. A start in the middle of a byte restarts the address phase.
- R10: Writes to registers 6 and 7 are acknowledged but change no output.
- R11: `sda_pull_o` changes only while SCL is low, except when a start or stop releases it. It is never asserted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap that sets device address bit 5 |
| stat_i | input | 16 | Status bytes readable at registers 6 and 7 |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| ctrl_o | output | 48 | Control registers 0 to 5, register k at bits 8k+7:8k |

## Verification
A wrong state or bit count shows up at the ports within one byte. The acknowledge either appears in the wrong SCL pulse or is missing, and the register named in the transaction is left unchanged or is corrupted. A pointer that advances or saturates wrongly shows up in the next byte read, as the value of the wrong register. A missed abort shows up as a write that should not have happened, or as a lost acknowledge on the next transfer.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } rf_state_t;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank #(
  parameter int NUM_REGS = 8,
  parameter int NUM_CTRL = 6,
  localparam int NUM_STAT = NUM_REGS - NUM_CTRL,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [AW-1:0]         raddr,
  input  logic [NUM_STAT*8-1:0] stat_i,
  output logic [7:0]            rdata,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic [7:0] rd_arr [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    if (k < NUM_CTRL) begin : g_ctrl
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= 8'h00;
        else if (we && waddr == AW'(k))      q <= wdata;
      end
      assign ctrl_o[k*8 +: 8] = q;
      assign rd_arr[k] = q;
    end else begin : g_stat
      assign rd_arr[k] = stat_i[(k-NUM_CTRL)*8 +: 8];
    end
  end

  assign rdata = rd_arr[raddr];

  // R10: writes aimed at status slots leave every control output untouched
  p_ro_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(waddr) >= NUM_CTRL) |=> $stable(ctrl_o));
endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
  import i2c_rf_pkg::*;
#(
  parameter int          NUM_REGS  = 8,
  parameter logic [6:0]  ADDR_BASE = 7'h40,
  parameter int          STRAP_POS = 5,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_strap_i,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          sda_pull
);
  rf_state_t   st;
  logic [2:0]  cnt;
  logic [6:0]  sh;
  logic [7:0]  tx;
  logic [1:0]  ph;
  logic        rw;
  logic [7:0]  byte_in;
  logic [6:0]  dev_addr;
  logic [AW-1:0] ptr_inc;

  assign byte_in  = {sh, sda_s};
  assign dev_addr = ADDR_BASE | (7'(addr_strap_i) << STRAP_POS);
  assign ptr_inc  = (ptr == AW'(NUM_REGS-1)) ? ptr : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ph <= '0; rw <= 1'b0;
      ptr <= '0; we <= 1'b0; waddr <= '0; wdata <= '0; sda_pull <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_SUB, ST_WR: begin
            if (scl_rise) begin
              sh  <= byte_in[6:0];
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                ph <= 2'd0;
                if (st == ST_ADDR) begin
                  if (byte_in[7:1] == dev_addr) begin
                    rw <= byte_in[0];
                    st <= ST_ADDR_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end else if (st == ST_SUB) begin
                  if (byte_in < 8'(NUM_REGS)) begin
                    ptr <= byte_in[AW-1:0];
                    st  <= ST_SUB_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end else begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= byte_in;
                  ptr   <= ptr_inc;
                  st    <= ST_WR_ACK;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_SUB_ACK, ST_WR_ACK: begin
            if (scl_fall && ph == 2'd0) begin
              sda_pull <= 1'b1; ph <= 2'd1;
            end else if (scl_rise && ph == 2'd1) begin
              ph <= 2'd2;
            end else if (scl_fall && ph == 2'd2) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              if (st == ST_ADDR_ACK && rw) begin
                tx       <= rdata;
                sda_pull <= ~rdata[7];
                ptr      <= ptr_inc;
                st       <= ST_RD;
              end else if (st == ST_ADDR_ACK) begin
                st <= ST_SUB;
              end else begin
                st <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                st <= ST_RD_ACK; ph <= 2'd0;
              end
            end else if (scl_fall) begin
              tx       <= {tx[6:0], 1'b0};
              sda_pull <= ~tx[6];
            end
          end
          ST_RD_ACK: begin
            if (scl_fall && ph == 2'd0) begin
              sda_pull <= 1'b0; ph <= 2'd1;
            end else if (scl_rise && ph == 2'd1) begin
              if (sda_s) st <= ST_IDLE;
              else       ph <= 2'd2;
            end else if (scl_fall && ph == 2'd2) begin
              tx       <= rdata;
              sda_pull <= ~rdata[7];
              ptr      <= ptr_inc;
              cnt      <= '0;
              st       <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: the pull enable moves only while SCL is low, unless a start/stop forced release
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_s));

  // R8: an idle slave never holds the line low
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);

  // R9: a stop always lands in idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));

  // R9: a start always restarts the address phase from bit zero
  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && cnt == 3'd0));

  // R4: a register write is only issued from the data phase
  p_write_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($past(st) == ST_WR && $past(scl_rise)));
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int          NUM_REGS  = 8,
  parameter int          NUM_CTRL  = 6,
  parameter logic [6:0]  ADDR_BASE = 7'h40,
  parameter int          STRAP_POS = 5,
  localparam int NUM_STAT = NUM_REGS - NUM_CTRL,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_strap_i,
  input  logic [NUM_STAT*8-1:0] stat_i,
  output logic                  sda_pull_o,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic we;
  logic [AW-1:0] waddr, ptr;
  logic [7:0] wdata, rdata;

  i2c_rf_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rf_fsm #(.NUM_REGS(NUM_REGS), .ADDR_BASE(ADDR_BASE), .STRAP_POS(STRAP_POS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_strap_i(addr_strap_i), .rdata(rdata), .ptr(ptr),
    .we(we), .waddr(waddr), .wdata(wdata), .sda_pull(sda_pull_o)
  );

  i2c_rf_regbank #(.NUM_REGS(NUM_REGS), .NUM_CTRL(NUM_CTRL)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .stat_i(stat_i), .rdata(rdata), .ctrl_o(ctrl_o)
  );
endmodule

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
  localparam int Q = 6;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, m_low, strap;
  logic [15:0] stat;
  logic sda_pull;
  logic [47:0] ctrl;
  wire sda_line = ~(m_low | sda_pull);

  int checks = 0, errors = 0;
  logic [7:0] model [6];
  logic [7:0] wbuf [8];

  i2c_regfile_slave u_i2c_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(strap), .stat_i(stat), .sda_pull_o(sda_pull), .ctrl_o(ctrl)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  function automatic logic [6:0] devaddr();
    return 7'h40 | (7'(strap) << 5);
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    return (p < 6) ? model[p] : stat[(p-6)*8 +: 8];
  endfunction

  function automatic int sat(input int p);
    return (p >= 7) ? 7 : p + 1;
  endfunction

  task automatic i2c_start();
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw(); qw();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); d[i] = sda_line; qw(); scl = 1'b0;
    end
    qw();
    m_low = ~nack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); m_low = 1'b0;
  endtask

  task automatic check_ctrl(input string tag);
    for (int k = 0; k < 6; k++) chk(tag, ctrl[k*8 +: 8], model[k]);
  endtask

  task automatic wr_txn(input logic [7:0] sub, input int n, input string tag);
    logic ack;
    int p;
    i2c_start();
    send_byte({devaddr(), 1'b0}, ack); chk("R2 address ack", ack, 1);
    send_byte(sub, ack);
    if (sub < 8) chk("R4 subaddress ack", ack, 1);
    else         chk("R6 bad subaddress nack", ack, 0);
    p = sub;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (sub < 8) begin
        chk({tag, " data ack"}, ack, 1);
        if (p < 6) model[p] = wbuf[i];
        p = sat(p);
      end else begin
        chk("R6 data after bad subaddress", ack, 0);
      end
    end
    i2c_stop();
    check_ctrl(tag);
  endtask

  task automatic rd_txn(input int sub, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    int p;
    i2c_start();
    send_byte({devaddr(), 1'b0}, ack); chk("R2 address ack", ack, 1);
    send_byte(8'(sub), ack); chk("R7 subaddress ack", ack, 1);
    i2c_start();
    send_byte({devaddr(), 1'b1}, ack); chk("R7 read address ack", ack, 1);
    p = sub;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n-1, d);
      chk(tag, d, exp_rd(p));
      p = sat(p);
    end
  endtask

  initial begin
    int unused;
    logic ack;
    logic [7:0] d;
    unused = $urandom(32'h5eed);
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; strap = 1'b0; stat = 16'hB75C;
    for (int k = 0; k < 6; k++) model[k] = 8'h00;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1; qw();

    // R1 reset state
    check_ctrl("R1 reset value");
    chk("R1 pull released", sda_pull, 0);

    // R3: wrong address (0x60 while strap=0) is ignored
    i2c_start();
    send_byte({7'h60, 1'b0}, ack); chk("R3 mismatch nack", ack, 0);
    send_byte(8'h02, ack); chk("R3 sub ignored", ack, 0);
    send_byte(8'hA5, ack); chk("R3 data ignored", ack, 0);
    i2c_stop();
    check_ctrl("R3 no write");

    // R2: strap selects 0x60; R4/R5 consecutive write
    strap = 1'b1;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(8'h00, 3, "R5 auto-increment write");

    // R6: invalid subaddress
    wbuf[0] = 8'hEE;
    wr_txn(8'h08, 1, "R6 no write");

    // R10: writes to status slots and past the top are discarded
    wbuf[0] = 8'h99; wbuf[1] = 8'h98; wbuf[2] = 8'h97; wbuf[3] = 8'h96;
    wr_txn(8'h04, 4, "R10 read-only write");

    // R7: read with auto-increment across the status slots
    rd_txn(3, 5, "R7 read data");
    i2c_stop();

    // R8: read past the top repeats register 7, then released after nack
    rd_txn(5, 5, "R8 saturated read");
    recv_byte(1'b1, d); chk("R8 line free after nack", d, 8'hFF);
    i2c_stop();

    // R9: stop in the middle of a data byte
    i2c_start();
    send_byte({devaddr(), 1'b0}, ack);
    send_byte(8'h02, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop();
    check_ctrl("R9 stop abort");

    // R9: start in the middle of a data byte, then a clean write
    i2c_start();
    send_byte({devaddr(), 1'b0}, ack);
    send_byte(8'h01, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    i2c_start();
    send_byte({devaddr(), 1'b0}, ack); chk("R9 restart address ack", ack, 1);
    send_byte(8'h01, ack); chk("R9 restart sub ack", ack, 1);
    send_byte(8'h5A, ack); chk("R9 restart data ack", ack, 1);
    model[1] = 8'h5A;
    i2c_stop();
    check_ctrl("R9 start abort");

    // random mix
    for (int t = 0; t < 30; t++) begin
      strap = 1'($urandom);
      if ($urandom % 2 == 0) begin
        logic [7:0] sub;
        int n;
        sub = ($urandom % 8 == 0) ? 8'(8 + $urandom % 248) : 8'($urandom % 8);
        n = 1 + $urandom % 4;
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_txn(sub, n, "R5 random write");
      end else begin
        rd_txn($urandom % 8, 1 + $urandom % 4, "R7 random read");
        i2c_stop();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule